// File: doc/BRIEF.md
# Transponder Memory Access Permission Unit

This block sits between the command logic of a contactless memory tag and its word-addressed store. It decides, for every read or write request, whether that access may proceed. A read that is allowed but touches a protected word must have its data replaced by zeros. The store holds 34 words: words 0 to 31 are rewritable, and words 32 and 33 are factory-fixed identity words. Word 0 holds the secret password, word 1 the protection ranges and word 2 the configuration.

The unit keeps its own copies of the protection word and the configuration bits, and it holds the stored password. A small session state machine has two states, `SESS_LOCKED` and `SESS_OPEN`, and starts in `SESS_LOCKED` after reset. When a password compare is requested, a match takes the machine to `SESS_OPEN` (transition *login-ok*). A mismatch takes it to `SESS_LOCKED` (transition *login-fail*). With no compare request the state holds (transition *hold*). A session counts as authorised when it is open, or when the configuration disables password checking. Every decision is combinational from the request and the registered state, so it is valid in the same cycle as the request.

Top module: `tag_access_guard`

## Requirements
- R1: After reset the session is `SESS_LOCKED` (`logged_in`=0), the stored password is all zeros, the protection copy is zero, and the configuration copy has only bit 16 set. That means password checking is on, `verify_en`=0 and both scan bounds are 0.
- R2: A `login_req` pulse whose `login_pw` equals the stored password sets `logged_in` from the next cycle. A pulse with any other value clears it from the next cycle.
- R3: A read of address 0 is always refused, with `grant`=0 and `mask_data`=1, whatever the session or configuration.
- R4: A read of an address from 1 to 33 is granted. `mask_data` is 1 exactly when the address lies inside the inclusive range from protection bits [7:0] (low bound) to [15:8] (high bound) and the session is not authorised.
- R5: A write to an address from 3 to 31 is refused when the address lies inside the inclusive range from protection bits [23:16] to [31:24], even when authorised. Otherwise it is granted.
- R6: A write to addresses 0, 1 or 2 is granted only when the session is authorised, and is never affected by the write-inhibit range.
- R7: Writes to addresses 32 and above are always refused. Reads of addresses 34 to 63 are refused with `mask_data`=1.
- R8: Configuration bit 16 = 1 makes authorisation equal to `logged_in`. Bit 16 = 0 makes every session authorised.
- R9: A `pw_set` pulse replaces the stored password with `pw_new` only when the session is authorised. Otherwise the stored password is unchanged.
- R10: `verify_en` follows configuration bit 17. `scan_first` follows bits [7:0] and `scan_last` follows bits [15:8].
- R11: With `req_valid`=0 both `grant` and `mask_data` are 0. A write never raises `mask_data`.
- R12: `ctrl_load` and `prot_load` capture their inputs at a clock edge, and decisions from the next cycle use the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_load | input | 1 | Capture `ctrl_in` into the configuration copy |
| ctrl_in | input | 18 | Configuration bits 17..0 |
| prot_load | input | 1 | Capture `prot_in` into the protection copy |
| prot_in | input | 32 | Protection word |
| login_req | input | 1 | Compare `login_pw` with the stored password |
| login_pw | input | 32 | Submitted password |
| pw_set | input | 1 | Request a password update |
| pw_new | input | 32 | New password value |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 6 | Word address |
| grant | output | 1 | Access allowed |
| mask_data | output | 1 | Read data must be forced to zero |
| logged_in | output | 1 | Session is `SESS_OPEN` |
| verify_en | output | 1 | Read-after-write enable from configuration |
| scan_first | output | 8 | First word of the continuous read window |
| scan_last | output | 8 | Last word of the continuous read window |

## Verification
The clocked properties sample the request, login and update inputs at the rising edge. They assume the driver holds those inputs steady across the edge and gives each `login_req` or `pw_set` a one-cycle pulse. The stimulus changes every input one time unit after a rising edge and lowers each pulse after one edge, so each pulse is seen exactly once. Random protection bounds are drawn from 0 to 36, so the ranges often straddle the system words, the factory words and addresses past the last valid word. Random logins use the correct password in about half of the attempts, so the machine takes both compare transitions.

// File: rtl/tag_access_pkg.sv
package tag_access_pkg;

    // configuration bit positions decoded by this block
    localparam int CHK_BIT = 16;
    localparam int RAW_BIT = 17;
    localparam int CTRL_W  = RAW_BIT + 1;

    // session state of the login machine
    typedef enum logic [0:0] {
        SESS_LOCKED = 1'b0,
        SESS_OPEN   = 1'b1
    } sess_state_t;

endpackage

// File: rtl/tag_range_match.sv
module tag_range_match #(
    parameter int ADDR_W  = 6,
    parameter int FIELD_W = 8
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic [FIELD_W-1:0] lo,
    input  logic [FIELD_W-1:0] hi,
    output logic               hit
);
    localparam int PAD_W = FIELD_W - ADDR_W;

    logic [FIELD_W-1:0] addr_ext;

    assign addr_ext = {{PAD_W{1'b0}}, addr};

    // inclusive bounds; lo above hi gives an empty range
    always_comb begin
        hit = (addr_ext >= lo) && (addr_ext <= hi);
    end
endmodule

// File: rtl/tag_login_fsm.sv
module tag_login_fsm
    import tag_access_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              login_req,
    input  logic [DATA_W-1:0] login_pw,
    input  logic              pw_set,
    input  logic [DATA_W-1:0] pw_new,
    input  logic              chk_en,
    output logic              logged_in,
    output logic              auth
);
    sess_state_t       state_q;
    sess_state_t       state_d;
    logic [DATA_W-1:0] pw_q;
    logic              pw_match;

    assign pw_match = (login_pw == pw_q);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SESS_LOCKED;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: login-ok, login-fail, hold
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SESS_LOCKED: begin
                if (login_req && pw_match) begin
                    state_d = SESS_OPEN;
                end
            end
            SESS_OPEN: begin
                if (login_req && !pw_match) begin
                    state_d = SESS_LOCKED;
                end
            end
            default: state_d = SESS_LOCKED;
        endcase
    end

    // outputs
    always_comb begin
        logged_in = 1'b0;
        unique case (state_q)
            SESS_LOCKED: logged_in = 1'b0;
            SESS_OPEN:   logged_in = 1'b1;
            default:     logged_in = 1'b0;
        endcase
        auth = logged_in || !chk_en;
    end

    // stored password
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pw_q <= '0;
        end else if (pw_set && auth) begin
            pw_q <= pw_new;
        end
    end

    // R2
    login_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (login_req && (login_pw != pw_q)) |=> !logged_in);

    // R2
    login_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (login_req && (login_pw == pw_q)) |=> logged_in);

    // R9
    pw_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pw_set && !logged_in && chk_en) |=> $stable(pw_q));

endmodule

// File: rtl/tag_access_decide.sv
module tag_access_decide #(
    parameter int ADDR_W    = 6,
    parameter int EE_WORDS  = 32,
    parameter int ROM_WORDS = 2,
    parameter int SYS_WORDS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              rd_hit,
    input  logic              wr_hit,
    input  logic              auth,
    output logic              grant,
    output logic              mask_data
);
    localparam int TOTAL_WORDS = EE_WORDS + ROM_WORDS;
    localparam logic [ADDR_W:0] LIM_ALL = (ADDR_W + 1)'(TOTAL_WORDS);
    localparam logic [ADDR_W:0] LIM_EE  = (ADDR_W + 1)'(EE_WORDS);
    localparam logic [ADDR_W:0] LIM_SYS = (ADDR_W + 1)'(SYS_WORDS);

    logic [ADDR_W:0] addr_x;
    logic            is_secret;
    logic            in_sys;
    logic            in_ee;
    logic            in_map;

    assign addr_x    = {1'b0, req_addr};
    assign is_secret = (req_addr == '0);
    assign in_sys    = (addr_x < LIM_SYS);
    assign in_ee     = (addr_x < LIM_EE);
    assign in_map    = (addr_x < LIM_ALL);

    always_comb begin
        grant     = 1'b0;
        mask_data = 1'b0;
        if (req_valid) begin
            if (req_write) begin
                if (in_sys) begin
                    grant = auth;
                end else if (in_ee) begin
                    grant = !wr_hit;
                end
            end else begin
                if (in_map && !is_secret) begin
                    grant     = 1'b1;
                    mask_data = rd_hit && !auth;
                end else begin
                    mask_data = 1'b1;
                end
            end
        end
    end

    // R3
    pw_unreadable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_addr == '0) |-> (!grant && mask_data));

    // R7
    rom_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !in_ee) |-> !grant);

    // R5
    inhibit_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !in_sys && wr_hit) |-> !grant);

    // R11
    write_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid || req_write) |-> !mask_data);

endmodule

// File: rtl/tag_access_guard.sv
module tag_access_guard
    import tag_access_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int DATA_W    = 32,
    parameter int FIELD_W   = 8,
    parameter int EE_WORDS  = 32,
    parameter int ROM_WORDS = 2,
    parameter int SYS_WORDS = 3,
    parameter logic [CTRL_W-1:0] CTRL_RST = CTRL_W'(1) << CHK_BIT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctrl_load,
    input  logic [CTRL_W-1:0]  ctrl_in,
    input  logic               prot_load,
    input  logic [DATA_W-1:0]  prot_in,
    input  logic               login_req,
    input  logic [DATA_W-1:0]  login_pw,
    input  logic               pw_set,
    input  logic [DATA_W-1:0]  pw_new,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    output logic               grant,
    output logic               mask_data,
    output logic               logged_in,
    output logic               verify_en,
    output logic [FIELD_W-1:0] scan_first,
    output logic [FIELD_W-1:0] scan_last
);
    localparam int NUM_RANGES = DATA_W / (2 * FIELD_W);
    localparam int RD_RANGE   = 0;
    localparam int WR_RANGE   = 1;

    logic [CTRL_W-1:0]     ctrl_q;
    logic [DATA_W-1:0]     prot_q;
    logic [NUM_RANGES-1:0] hit;
    logic                  auth;

    // configuration copies
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RST;
            prot_q <= '0;
        end else begin
            if (ctrl_load) begin
                ctrl_q <= ctrl_in;
            end
            if (prot_load) begin
                prot_q <= prot_in;
            end
        end
    end

    assign verify_en  = ctrl_q[RAW_BIT];
    assign scan_first = ctrl_q[FIELD_W-1:0];
    assign scan_last  = ctrl_q[2*FIELD_W-1:FIELD_W];

    // one comparator pair per protection range
    for (genvar g = 0; g < NUM_RANGES; g++) begin : g_rng
        tag_range_match #(
            .ADDR_W (ADDR_W),
            .FIELD_W(FIELD_W)
        ) u_rm (
            .addr(req_addr),
            .lo  (prot_q[g*2*FIELD_W +: FIELD_W]),
            .hi  (prot_q[g*2*FIELD_W+FIELD_W +: FIELD_W]),
            .hit (hit[g])
        );
    end

    tag_login_fsm #(
        .DATA_W(DATA_W)
    ) u_login (
        .clk      (clk),
        .rst_n    (rst_n),
        .login_req(login_req),
        .login_pw (login_pw),
        .pw_set   (pw_set),
        .pw_new   (pw_new),
        .chk_en   (ctrl_q[CHK_BIT]),
        .logged_in(logged_in),
        .auth     (auth)
    );

    tag_access_decide #(
        .ADDR_W   (ADDR_W),
        .EE_WORDS (EE_WORDS),
        .ROM_WORDS(ROM_WORDS),
        .SYS_WORDS(SYS_WORDS)
    ) u_decide (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_write(req_write),
        .req_addr (req_addr),
        .rd_hit   (hit[RD_RANGE]),
        .wr_hit   (hit[WR_RANGE]),
        .auth     (auth),
        .grant    (grant),
        .mask_data(mask_data)
    );

    // R8
    nocheck_auth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q[CHK_BIT] && req_valid && !req_write && req_addr != '0
         && {1'b0, req_addr} < (ADDR_W + 1)'(EE_WORDS + ROM_WORDS)) |-> !mask_data);

endmodule

// File: tb/sim_tag_access_guard.sv
`timescale 1ns/1ps
module sim_tag_access_guard;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ctrl_load;
    logic [17:0] ctrl_in;
    logic        prot_load;
    logic [31:0] prot_in;
    logic        login_req;
    logic [31:0] login_pw;
    logic        pw_set;
    logic [31:0] pw_new;
    logic        req_valid;
    logic        req_write;
    logic [5:0]  req_addr;
    logic        grant;
    logic        mask_data;
    logic        logged_in;
    logic        verify_en;
    logic [7:0]  scan_first;
    logic [7:0]  scan_last;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // bench model of the state visible through the ports
    logic [17:0] m_ctrl;
    logic [31:0] m_prot;
    logic [31:0] m_pw;
    logic        m_li;

    always #4 clk = ~clk;

    tag_access_guard u0 (
        .clk(clk), .rst_n(rst_n),
        .ctrl_load(ctrl_load), .ctrl_in(ctrl_in),
        .prot_load(prot_load), .prot_in(prot_in),
        .login_req(login_req), .login_pw(login_pw),
        .pw_set(pw_set), .pw_new(pw_new),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .grant(grant), .mask_data(mask_data), .logged_in(logged_in),
        .verify_en(verify_en), .scan_first(scan_first), .scan_last(scan_last)
    );

    function automatic logic in_rng(logic [5:0] a, logic [7:0] lo, logic [7:0] hi);
        return ({2'b00, a} >= lo) && ({2'b00, a} <= hi);
    endfunction

    function automatic logic [1:0] exp_acc(logic v, logic w, logic [5:0] a);
        logic au;
        logic g;
        logic m;
        au = m_li || !m_ctrl[16];
        g  = 1'b0;
        m  = 1'b0;
        if (v) begin
            if (w) begin
                if (a < 6'd3)       g = au;
                else if (a < 6'd32) g = !in_rng(a, m_prot[23:16], m_prot[31:24]);
            end else if (a != 6'd0 && a < 6'd34) begin
                g = 1'b1;
                m = in_rng(a, m_prot[7:0], m_prot[15:8]) && !au;
            end else begin
                m = 1'b1;
            end
        end
        return {g, m};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic load_cfg(logic [17:0] c, logic [31:0] p);
        ctrl_load = 1'b1; ctrl_in = c;
        prot_load = 1'b1; prot_in = p;
        tick();
        ctrl_load = 1'b0; prot_load = 1'b0;
        m_ctrl = c; m_prot = p;
    endtask

    task automatic login(logic [31:0] pw, string req);
        login_req = 1'b1; login_pw = pw;
        tick();
        login_req = 1'b0;
        m_li = (pw == m_pw);
        check(req, 32'(logged_in), 32'(m_li));
    endtask

    task automatic set_pw(logic [31:0] nv);
        pw_set = 1'b1; pw_new = nv;
        tick();
        pw_set = 1'b0;
        if (m_li || !m_ctrl[16]) m_pw = nv;
    endtask

    task automatic probe(logic w, logic [5:0] a, string req);
        logic [1:0] e;
        req_valid = 1'b1; req_write = w; req_addr = a;
        #1;
        e = exp_acc(1'b1, w, a);
        check(req, {30'd0, grant, mask_data}, {30'd0, e});
        req_valid = 1'b0;
        #1;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        int unsigned seed_v;
        seed_v = $urandom(32'd2024);
        rst_n = 1'b0; ctrl_load = 1'b0; ctrl_in = '0; prot_load = 1'b0; prot_in = '0;
        login_req = 1'b0; login_pw = '0; pw_set = 1'b0; pw_new = '0;
        req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
        m_ctrl = 18'h10000; m_prot = '0; m_pw = '0; m_li = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        check("R1 logged_in", 32'(logged_in), 32'd0);
        check("R1 verify_en", 32'(verify_en), 32'd0);
        check("R1 scan bounds", {16'd0, scan_last, scan_first}, 32'd0);
        // R11 idle outputs
        #1;
        check("R11 idle", {30'd0, grant, mask_data}, 32'd0);
        // R4 reset protection covers only word 0: word 5 readable unmasked
        probe(1'b0, 6'd5, "R4 reset read");
        // R8 check on and locked: system write refused
        probe(1'b1, 6'd2, "R8 locked sys write");
        // R1 default password is zero
        login(32'd0, "R1 zero password login");
        // R2 wrong password clears session
        login(32'hDEAD_BEEF, "R2 bad login clears");
        login(32'd0, "R2 good login");

        // R12 / R10 load and observe next cycle
        load_cfg(18'h2_0A05, 32'h0905_0C0A);
        check("R10 verify_en", 32'(verify_en), 32'd1);
        check("R10 scan bounds", {16'd0, scan_last, scan_first}, 32'h0000_0A05);
        // R5 edges of write-inhibit range 5..9 while logged in
        probe(1'b1, 6'd4,  "R5 below range");
        probe(1'b1, 6'd5,  "R5 low bound");
        probe(1'b1, 6'd9,  "R5 high bound");
        probe(1'b1, 6'd10, "R5 above range");
        // R3 secret word unreadable even logged in
        probe(1'b0, 6'd0, "R3 secret read logged in");
        // R7 factory words and unmapped addresses
        probe(1'b1, 6'd32, "R7 write 32");
        probe(1'b1, 6'd33, "R7 write 33");
        probe(1'b0, 6'd33, "R7 read 33");
        probe(1'b0, 6'd40, "R7 read 40");
        probe(1'b1, 6'd63, "R7 write 63");
        // R4 read range 10..12, locked
        login(32'h1234_5678, "R2 bad login");
        probe(1'b0, 6'd9,  "R4 below range");
        probe(1'b0, 6'd10, "R4 low bound");
        probe(1'b0, 6'd12, "R4 high bound");
        probe(1'b0, 6'd13, "R4 above range");
        // R6 inhibit covering all, system words exempt, need login
        load_cfg(18'h1_0000, 32'h1F00_0000);
        probe(1'b1, 6'd1, "R6 locked sys write");
        probe(1'b1, 6'd3, "R5 inhibited user word");
        login(32'd0, "R2 relogin");
        probe(1'b1, 6'd1, "R6 open sys write");
        probe(1'b1, 6'd0, "R6 open pw write");
        // R8 check off: authorised while locked
        login(32'h1, "R2 bad login");
        load_cfg(18'h0_0000, 32'h0000_0F00);
        probe(1'b0, 6'd7, "R8 unmasked with check off");
        probe(1'b1, 6'd2, "R8 sys write with check off");
        // R9 update ignored when locked and check on
        load_cfg(18'h1_0000, 32'h0);
        set_pw(32'hCAFE_0001);
        login(32'hCAFE_0001, "R9 ignored update not accepted");
        login(32'd0, "R9 old password still valid");
        set_pw(32'hCAFE_0002);
        login(32'd0, "R9 old password rejected");
        login(32'hCAFE_0002, "R9 new password accepted");

        // random phase
        for (int i = 0; i < 600; i++) begin
            int unsigned op;
            op = $urandom_range(0, 9);
            if (op == 0) begin
                load_cfg({$urandom_range(0, 3) != 0 ? 1'b1 : 1'b0, 1'b1, 16'($urandom)} ^ 18'h20000,
                         {8'($urandom_range(0, 36)), 8'($urandom_range(0, 36)),
                          8'($urandom_range(0, 36)), 8'($urandom_range(0, 36))});
                check("R10 random verify", 32'(verify_en), 32'(m_ctrl[17]));
            end else if (op == 1) begin
                login(($urandom_range(0, 1) == 1) ? m_pw : $urandom, "R2 random login");
            end else if (op == 2) begin
                set_pw($urandom_range(0, 1) == 1 ? m_pw ^ 32'h1 : $urandom);
            end else begin
                logic [5:0] a;
                a = ($urandom_range(0, 15) == 0) ? 6'($urandom) : 6'($urandom_range(0, 36));
                probe(1'($urandom), a, "R4 R5 R6 R7 random access");
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule